// File: doc/BRIEF.md
# Hardwired CPU Control Signal Generator

This block is the control unit of a small 32-bit CPU built around three internal buses: two source buses, B1 and B2, feed the ALU, and its result goes out on B3. Every cycle the block looks at the five opcode bits of the instruction register, the current major state and the current minor state. It drives one-hot select lines that choose the B1 and B2 sources, one-hot load strobes for the B3 destinations, a one-hot ALU operation, a 3-bit shift control, and the memory read, memory write, stall and run-clear strobes.

There is no microcode store. Each control line is a small sum-of-products tree over phase strobes and decoded instruction lines. Where whole opcode groups share a line during the last fetch step, the tree tests the opcode bits directly instead of listing each instruction.

The block also holds the sequencing state. A 2-bit minor counter steps T0 to T3 and wraps. On each wrap the major state moves from Fetch to Defer or Execute, from Defer to Execute, or from Execute back to Fetch. A run flag freezes all of this once a halt instruction has been fetched.

Top module: `hwctl_top`

## Requirements
- R1: A synchronous active-high reset puts the block in Fetch, T0 with run set to 1. Major states are encoded Fetch=0, Defer=1, Execute=2.
- R2: While run is 1, the minor state steps by one each clock and wraps from T3 to T0. At the wrap, Fetch goes to Defer if the indirect bit is 1 and to Execute if it is 0, Defer goes to Execute, and Execute goes to Fetch.
- R3: Fetch T0 asserts PC on B1, pass-B1, load MAR and memory read. Fetch T1 asserts PC on B1, constant 1 on B2, add and load PC. Fetch T2 asserts MBR on B2, pass-B2 and load IR.
- R4: The Defer steps drive, in order: T0 memory read only; T1 stall only; T2 MBR on B2, pass-B2, load MAR; T3 stall only. Memory write is never asserted in Defer.
- R5: In Fetch T3 with opcode bit 4 set, R drives B1 and B2 and B3 loads R. The ALU line is add for opcode 21, sub for 22, and for 23, or for 24, xor for 25, not for 20, shift for 16 to 19, and none for other codes.
- R6: In Fetch T3 with opcode bit 4 clear, IR drives B1 and R drives B2. Opcodes 12 to 15 also load MAR with add. Opcode 1 loads R with pass-B1, opcode 2 loads R with and, and opcode 3 loads R with add.
- R7: The shift control is 100 for opcode 16, 101 for 17, 000 for 18 and 010 for 19, and only in Fetch T3. It is 000 at all other times.
- R8: Opcode 0 asserts run-clear in Fetch T3 and clears run at that clock edge. While run is 0 the major state, minor state and run are held, and every control line is deasserted.
- R9: In Execute T0: opcode 8 routes IR via pass-B1 into IOA; 9 routes R via pass-B2 into IOD; 10 routes SP and constant -1 through add into SP; 12 asserts memory read; 14 routes PC via pass-B1 into MBR. In Execute T1: 10 routes SP via pass-B1 into MAR and asserts memory read; 13 routes R via pass-B1 into MBR and asserts memory write; 14 routes MAR via pass-B1 into PC.
- R10: In Execute T2: opcode 8 loads R from IOD via pass-B2; 9 loads IOA from IR via pass-B1; 12 loads R from MBR via pass-B2; 14 routes SP via pass-B1 into MAR and asserts memory write. In Execute T3: 10 loads PC from MBR via pass-B2; 14 routes SP and constant 1 through add into SP; 15 loads PC from MAR via pass-B1.
- R11: Any Execute step that R9 and R10 do not list for the current opcode deasserts every control line. This covers opcode 11 and unassigned codes.
- R12: Select one-hot positions are: B1 {0 PC, 1 IR, 2 R, 3 SP, 4 MAR}; B2 {0 const 1, 1 const -1, 2 MBR, 3 R, 4 IOD}; B3 {0 MAR, 1 PC, 2 IR, 3 R, 4 SP, 5 MBR, 6 IOA, 7 IOD}; ALU {0 pass-B1, 1 pass-B2, 2 add, 3 sub, 4 and, 5 or, 6 xor, 7 not, 8 shift}. At most one bit of B1, B2 and ALU is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_op | input | 5 | Opcode field (IR bits 31..27) |
| ir_ind | input | 1 | Indirect-address bit of IR |
| b1_src | output | 5 | One-hot B1 source select |
| b2_src | output | 5 | One-hot B2 source select |
| b3_load | output | 8 | B3 destination load strobes |
| alu_op | output | 9 | One-hot ALU operation |
| shift_ctl | output | 3 | Shift control code |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| stall | output | 1 | Wait strobe |
| run_clr | output | 1 | Run-clear strobe |
| run | output | 1 | Run flag |
| major | output | 2 | Major state |
| minor | output | 2 | Minor state |

## Verification
The halted condition is the hardest situation to reach from the ports. Only a halt fetch leads to it, nothing but a reset leaves it, and it freezes the sequence partway into Execute. The driver therefore places the halt opcode after every other instruction has run through its full sequence. It then expects several frozen, silent cycles, and finally issues a reset and one more instruction to show that running resumes. The Defer path is reached by holding the indirect bit high through a load and a subroutine call, so twelve-cycle sequences are checked as well as eight-cycle ones.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;

  localparam int OPW  = 5;
  localparam int NOPS = 1 << OPW;
  localparam int MINW = 2;
  localparam int B1W  = 5;
  localparam int B2W  = 5;
  localparam int B3W  = 8;
  localparam int ALUW = 9;
  localparam int SHW  = 3;

  typedef enum logic [1:0] {
    MJ_FETCH = 2'd0,
    MJ_DEFER = 2'd1,
    MJ_EXEC  = 2'd2
  } major_t;

  // B1 source positions
  localparam int S1_PC = 0, S1_IR = 1, S1_R = 2, S1_SP = 3, S1_MAR = 4;
  // B2 source positions
  localparam int S2_ONE = 0, S2_NEG = 1, S2_MBR = 2, S2_R = 3, S2_IOD = 4;
  // B3 destination positions
  localparam int D_MAR = 0, D_PC = 1, D_IR = 2, D_R = 3, D_SP = 4,
                 D_MBR = 5, D_IOA = 6, D_IOD = 7;
  // ALU operation positions
  localparam int A_P1 = 0, A_P2 = 1, A_ADD = 2, A_SUB = 3, A_AND = 4,
                 A_OR = 5, A_XOR = 6, A_NOT = 7, A_SHF = 8;

  // opcode values
  localparam int OP_HLT = 0,  OP_LDI = 1,  OP_ANDI = 2, OP_ADDI = 3;
  localparam int OP_GET = 8,  OP_PUT = 9,  OP_RET = 10, OP_RTI = 11;
  localparam int OP_LDR = 12, OP_STR = 13, OP_JSR = 14, OP_BR = 15;
  localparam int OP_LLS = 16, OP_LCS = 17, OP_RLS = 18, OP_RAS = 19;
  localparam int OP_NOT = 20, OP_ADD = 21, OP_SUB = 22, OP_AND = 23;
  localparam int OP_OR  = 24, OP_XOR = 25;

  typedef struct packed {
    logic [B1W-1:0]  b1;
    logic [B2W-1:0]  b2;
    logic [B3W-1:0]  b3;
    logic [ALUW-1:0] alu;
    logic [SHW-1:0]  shf;
    logic            rd;
    logic            wr;
    logic            stall;
    logic            run_clr;
  } ctl_t;

  // Opcodes 0-3, 8-25 carry a meaning; everything else is unassigned.
  function automatic logic [NOPS-1:0] legal_mask();
    logic [NOPS-1:0] m;
    m = '0;
    for (int i = 0; i < NOPS; i++)
      m[i] = (i <= OP_ADDI) || (i >= OP_GET && i <= OP_XOR);
    return m;
  endfunction

  // Shift code selected by the decoded shift lines.
  function automatic logic [SHW-1:0] shift_code(logic lls, logic lcs, logic ras);
    logic [SHW-1:0] c;
    c = '0;
    if (lls) c = 3'b100;
    if (lcs) c = 3'b101;
    if (ras) c = 3'b010;
    return c;
  endfunction

  // Major state reached at the T3 -> T0 wrap.
  function automatic major_t major_after(major_t cur, logic ind);
    major_t n;
    case (cur)
      MJ_FETCH: n = ind ? MJ_DEFER : MJ_EXEC;
      MJ_DEFER: n = MJ_EXEC;
      default:  n = MJ_FETCH;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hwctl_dec.sv
module hwctl_dec
  import hwctl_pkg::*;
#(
  parameter int W = OPW,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] op,
  output logic [N-1:0] line
);

  for (genvar i = 0; i < N; i++) begin : g_line
    assign line[i] = (op == W'(i));
  end

endmodule

// File: rtl/hwctl_seq.sv
module hwctl_seq
  import hwctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ind,
  input  logic            run_clr,
  output major_t          major,
  output logic [MINW-1:0] minor,
  output logic            run,
  output logic            wrap
);

  localparam logic [MINW-1:0] LAST = {MINW{1'b1}};

  assign wrap = (minor == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      minor <= '0;
      major <= MJ_FETCH;
      run   <= 1'b1;
    end else if (run) begin
      minor <= minor + 1'b1;
      if (wrap) major <= major_after(major, ind);
      if (run_clr) run <= 1'b0;
    end
  end

endmodule

// File: rtl/hwctl_tree.sv
module hwctl_tree
  import hwctl_pkg::*;
(
  input  major_t          major,
  input  logic [MINW-1:0] minor,
  input  logic            run,
  input  logic [2:0]      ir_hi,   // IR31, IR30, IR29
  input  logic [NOPS-1:0] dec,
  output ctl_t            ctl
);

  localparam int NT = 1 << MINW;

  logic [NT-1:0] ft, dt, et;
  for (genvar k = 0; k < NT; k++) begin : g_phase
    assign ft[k] = run && (major == MJ_FETCH) && (minor == MINW'(k));
    assign dt[k] = run && (major == MJ_DEFER) && (minor == MINW'(k));
    assign et[k] = run && (major == MJ_EXEC)  && (minor == MINW'(k));
  end

  logic ir31, ir30, ir29;
  assign {ir31, ir30, ir29} = ir_hi;

  logic i_hlt, i_ldi, i_andi, i_addi, i_get, i_put, i_ret, i_ldr, i_str, i_jsr, i_br;
  logic i_lls, i_lcs, i_rls, i_ras, i_not, i_add, i_sub, i_and, i_or, i_xor;
  assign i_hlt  = dec[OP_HLT];
  assign i_ldi  = dec[OP_LDI];
  assign i_andi = dec[OP_ANDI];
  assign i_addi = dec[OP_ADDI];
  assign i_get  = dec[OP_GET];
  assign i_put  = dec[OP_PUT];
  assign i_ret  = dec[OP_RET];
  assign i_ldr  = dec[OP_LDR];
  assign i_str  = dec[OP_STR];
  assign i_jsr  = dec[OP_JSR];
  assign i_br   = dec[OP_BR];
  assign i_lls  = dec[OP_LLS];
  assign i_lcs  = dec[OP_LCS];
  assign i_rls  = dec[OP_RLS];
  assign i_ras  = dec[OP_RAS];
  assign i_not  = dec[OP_NOT];
  assign i_add  = dec[OP_ADD];
  assign i_sub  = dec[OP_SUB];
  assign i_and  = dec[OP_AND];
  assign i_or   = dec[OP_OR];
  assign i_xor  = dec[OP_XOR];

  // opcode-group shortcuts used in Fetch T3
  logic f3_dyad, f3_imm, f3_addr, f3_shift;
  assign f3_dyad  = ft[3] && ir31;
  assign f3_imm   = ft[3] && !ir31;
  assign f3_addr  = ft[3] && !ir31 && ir30 && ir29;
  assign f3_shift = ft[3] && (i_lls || i_lcs || i_rls || i_ras);

  always_comb begin
    ctl = '0;

    // B1 sources
    ctl.b1[S1_PC]  = ft[0] || ft[1] || (et[0] && i_jsr);
    ctl.b1[S1_IR]  = f3_imm || (et[0] && i_get) || (et[2] && i_put);
    ctl.b1[S1_R]   = f3_dyad || (et[1] && i_str);
    ctl.b1[S1_SP]  = (et[0] && i_ret) || (et[1] && i_ret) || (et[2] && i_jsr)
                   || (et[3] && i_jsr);
    ctl.b1[S1_MAR] = (et[1] && i_jsr) || (et[3] && i_br);

    // B2 sources
    ctl.b2[S2_ONE] = ft[1] || (et[3] && i_jsr);
    ctl.b2[S2_NEG] = et[0] && i_ret;
    ctl.b2[S2_MBR] = ft[2] || dt[2] || (et[2] && i_ldr) || (et[3] && i_ret);
    ctl.b2[S2_R]   = ft[3] || (et[0] && i_put);
    ctl.b2[S2_IOD] = et[2] && i_get;

    // B3 destinations
    ctl.b3[D_MAR] = ft[0] || dt[2] || f3_addr || (et[1] && i_ret) || (et[2] && i_jsr);
    ctl.b3[D_PC]  = ft[1] || (et[1] && i_jsr) || (et[3] && (i_ret || i_br));
    ctl.b3[D_IR]  = ft[2];
    ctl.b3[D_R]   = f3_dyad || (ft[3] && (i_ldi || i_andi || i_addi))
                  || (et[2] && (i_get || i_ldr));
    ctl.b3[D_SP]  = (et[0] && i_ret) || (et[3] && i_jsr);
    ctl.b3[D_MBR] = (et[0] && i_jsr) || (et[1] && i_str);
    ctl.b3[D_IOA] = (et[0] && i_get) || (et[2] && i_put);
    ctl.b3[D_IOD] = et[0] && i_put;

    // ALU operation
    ctl.alu[A_P1]  = ft[0] || (ft[3] && i_ldi) || (et[0] && (i_get || i_jsr))
                   || (et[1] && (i_ret || i_str || i_jsr)) || (et[2] && (i_put || i_jsr))
                   || (et[3] && i_br);
    ctl.alu[A_P2]  = ft[2] || dt[2] || (et[0] && i_put) || (et[2] && (i_get || i_ldr))
                   || (et[3] && i_ret);
    ctl.alu[A_ADD] = ft[1] || f3_addr || (ft[3] && (i_addi || i_add))
                   || (et[0] && i_ret) || (et[3] && i_jsr);
    ctl.alu[A_SUB] = ft[3] && i_sub;
    ctl.alu[A_AND] = ft[3] && (i_andi || i_and);
    ctl.alu[A_OR]  = ft[3] && i_or;
    ctl.alu[A_XOR] = ft[3] && i_xor;
    ctl.alu[A_NOT] = ft[3] && i_not;
    ctl.alu[A_SHF] = f3_shift;

    ctl.shf = f3_shift ? shift_code(i_lls, i_lcs, i_ras) : '0;

    // strobes
    ctl.rd      = ft[0] || dt[0] || (et[0] && i_ldr) || (et[1] && i_ret);
    ctl.wr      = (et[1] && i_str) || (et[2] && i_jsr);
    ctl.stall   = dt[1] || dt[3];
    ctl.run_clr = ft[3] && i_hlt;
  end

endmodule

// File: rtl/hwctl_top.sv
module hwctl_top
  import hwctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  ir_op,
  input  logic            ir_ind,
  output logic [B1W-1:0]  b1_src,
  output logic [B2W-1:0]  b2_src,
  output logic [B3W-1:0]  b3_load,
  output logic [ALUW-1:0] alu_op,
  output logic [SHW-1:0]  shift_ctl,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            stall,
  output logic            run_clr,
  output logic            run,
  output logic [1:0]      major,
  output logic [MINW-1:0] minor
);

  localparam logic [NOPS-1:0] LEGAL = legal_mask();

  logic [NOPS-1:0] dec_line;
  major_t          major_q;
  logic            seq_wrap;
  logic            op_legal;
  ctl_t            ctl;

  hwctl_dec #(.W(OPW)) u_dec (
    .op   (ir_op),
    .line (dec_line)
  );

  hwctl_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .ind     (ir_ind),
    .run_clr (ctl.run_clr),
    .major   (major_q),
    .minor   (minor),
    .run     (run),
    .wrap    (seq_wrap)
  );

  hwctl_tree u_tree (
    .major (major_q),
    .minor (minor),
    .run   (run),
    .ir_hi (ir_op[OPW-1:OPW-3]),
    .dec   (dec_line),
    .ctl   (ctl)
  );

  // named event for the checker: opcode has an assigned meaning
  assign op_legal = |(dec_line & LEGAL);

  assign major     = major_q;
  assign b1_src    = ctl.b1;
  assign b2_src    = ctl.b2;
  assign b3_load   = ctl.b3;
  assign alu_op    = ctl.alu;
  assign shift_ctl = ctl.shf;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign stall     = ctl.stall;
  assign run_clr   = ctl.run_clr;

endmodule

// File: rtl/hwctl_chk.sv
module hwctl_chk
  import hwctl_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [1:0]      major,
  input logic [MINW-1:0] minor,
  input logic            run,
  input logic            seq_wrap,
  input logic            op_legal,
  input logic [B1W-1:0]  b1_src,
  input logic [B2W-1:0]  b2_src,
  input logic [B3W-1:0]  b3_load,
  input logic [ALUW-1:0] alu_op,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            stall,
  input logic            run_clr
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (major == 2'd0 && minor == '0 && run));

  a_r2_minor_step: assert property (@(posedge clk) disable iff (rst)
    run |=> (minor == $past(minor) + 1'b1));

  a_r2_exec_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (run && seq_wrap && major == 2'd2) |=> (major == 2'd0));

  a_r2_defer_to_exec: assert property (@(posedge clk) disable iff (rst)
    (run && seq_wrap && major == 2'd1) |=> (major == 2'd2));

  a_r4_no_write_in_defer: assert property (@(posedge clk) disable iff (rst)
    (major == 2'd1) |-> !mem_wr);

  a_r8_clear_stops: assert property (@(posedge clk) disable iff (rst)
    run_clr |=> !run);

  a_r8_halt_holds: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!run && $stable(major) && $stable(minor)));

  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |-> (b1_src == '0 && b2_src == '0 && b3_load == '0 && alu_op == '0
              && !mem_rd && !mem_wr && !stall && !run_clr));

  a_r11_undef_exec_quiet: assert property (@(posedge clk) disable iff (rst)
    (major == 2'd2 && !op_legal) |-> (b3_load == '0 && !mem_rd && !mem_wr));

  a_r12_b1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(b1_src));

  a_r12_b2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(b2_src));

  a_r12_alu_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alu_op));

endmodule

bind hwctl_top hwctl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .major    (major),
  .minor    (minor),
  .run      (run),
  .seq_wrap (seq_wrap),
  .op_legal (op_legal),
  .b1_src   (b1_src),
  .b2_src   (b2_src),
  .b3_load  (b3_load),
  .alu_op   (alu_op),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .stall    (stall),
  .run_clr  (run_clr)
);

// File: tb/tb_hwctl_top.sv
module tb_hwctl_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ir_op = 5'd0;
  logic       ir_ind = 1'b0;
  logic [4:0] b1_src, b2_src;
  logic [7:0] b3_load;
  logic [8:0] alu_op;
  logic [2:0] shift_ctl;
  logic       mem_rd, mem_wr, stall, run_clr, run;
  logic [1:0] major, minor;

  always #4 clk = ~clk;   // 125 MHz

  hwctl_top dut (
    .clk(clk), .rst(rst), .ir_op(ir_op), .ir_ind(ir_ind),
    .b1_src(b1_src), .b2_src(b2_src), .b3_load(b3_load), .alu_op(alu_op),
    .shift_ctl(shift_ctl), .mem_rd(mem_rd), .mem_wr(mem_wr), .stall(stall),
    .run_clr(run_clr), .run(run), .major(major), .minor(minor)
  );

  typedef struct {
    logic [38:0] v;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Expected outputs per cycle, written from the requirement text.
  // Layout: {major, minor, run, b1, b2, b3, alu, shift, rd, wr, stall, run_clr}
  function automatic logic [38:0] expect_v(int mj, int mn, int op, bit rn);
    logic [4:0] b1 = '0, b2 = '0;
    logic [7:0] b3 = '0;
    logic [8:0] alu = '0;
    logic [2:0] sh = '0;
    logic rd = 0, wr = 0, st = 0, rc = 0;
    if (rn) begin
      if (mj == 0) begin
        case (mn)
          0: begin b1[0] = 1; alu[0] = 1; b3[0] = 1; rd = 1; end
          1: begin b1[0] = 1; b2[0] = 1; alu[2] = 1; b3[1] = 1; end
          2: begin b2[2] = 1; alu[1] = 1; b3[2] = 1; end
          default: begin
            b2[3] = 1;
            if (op >= 16) begin b1[2] = 1; b3[3] = 1; end
            else b1[1] = 1;
            case (op)
              0:  rc = 1;
              1:  begin b3[3] = 1; alu[0] = 1; end
              2:  begin b3[3] = 1; alu[4] = 1; end
              3:  begin b3[3] = 1; alu[2] = 1; end
              12, 13, 14, 15: begin b3[0] = 1; alu[2] = 1; end
              16: begin alu[8] = 1; sh = 3'b100; end
              17: begin alu[8] = 1; sh = 3'b101; end
              18: begin alu[8] = 1; sh = 3'b000; end
              19: begin alu[8] = 1; sh = 3'b010; end
              20: alu[7] = 1;
              21: alu[2] = 1;
              22: alu[3] = 1;
              23: alu[4] = 1;
              24: alu[5] = 1;
              25: alu[6] = 1;
              default: ;
            endcase
          end
        endcase
      end else if (mj == 1) begin
        case (mn)
          0: rd = 1;
          2: begin b2[2] = 1; alu[1] = 1; b3[0] = 1; end
          default: st = 1;
        endcase
      end else begin
        case (mn)
          0: case (op)
               8:  begin b1[1] = 1; alu[0] = 1; b3[6] = 1; end
               9:  begin b2[3] = 1; alu[1] = 1; b3[7] = 1; end
               10: begin b1[3] = 1; b2[1] = 1; alu[2] = 1; b3[4] = 1; end
               12: rd = 1;
               14: begin b1[0] = 1; alu[0] = 1; b3[5] = 1; end
               default: ;
             endcase
          1: case (op)
               10: begin b1[3] = 1; alu[0] = 1; b3[0] = 1; rd = 1; end
               13: begin b1[2] = 1; alu[0] = 1; b3[5] = 1; wr = 1; end
               14: begin b1[4] = 1; alu[0] = 1; b3[1] = 1; end
               default: ;
             endcase
          2: case (op)
               8:  begin b2[4] = 1; alu[1] = 1; b3[3] = 1; end
               9:  begin b1[1] = 1; alu[0] = 1; b3[6] = 1; end
               12: begin b2[2] = 1; alu[1] = 1; b3[3] = 1; end
               14: begin b1[3] = 1; alu[0] = 1; b3[0] = 1; wr = 1; end
               default: ;
             endcase
          default: case (op)
               10: begin b2[2] = 1; alu[1] = 1; b3[1] = 1; end
               14: begin b1[3] = 1; b2[0] = 1; alu[2] = 1; b3[4] = 1; end
               15: begin b1[4] = 1; alu[0] = 1; b3[1] = 1; end
               default: ;
             endcase
        endcase
      end
    end
    return {2'(mj), 2'(mn), rn, b1, b2, b3, alu, sh, rd, wr, st, rc};
  endfunction

  function automatic string tag_of(int mj, int mn, int op, bit rn, logic [38:0] v);
    if (!rn) return "R8";
    if (mj == 0) begin
      if (mn < 3) return "R3";
      if (op == 0) return "R8";
      if (op >= 16 && op <= 19) return "R7";
      return (op >= 16) ? "R5" : "R6";
    end
    if (mj == 1) return (mn == 0) ? "R2/R4" : "R4";
    if (v[33:0] == '0) return (mn == 0) ? "R2/R11" : "R11";
    if (mn < 2) return (mn == 0) ? "R2/R9" : "R9";
    return "R10";
  endfunction

  task automatic push(int mj, int mn, int op, bit rn, string force_tag = "");
    item_t it;
    it.v   = expect_v(mj, mn, op, rn);
    it.req = (force_tag != "") ? force_tag : tag_of(mj, mn, op, rn, it.v);
    q.push_back(it);
  endtask

  // Called one time unit after a clock edge that leaves the block in Fetch T0.
  task automatic run_instr(int op, bit ind, string first_tag = "");
    ir_op  = op[4:0];
    ir_ind = ind;
    for (int mn = 0; mn < 4; mn++) push(0, mn, op, 1'b1, (mn == 0) ? first_tag : "");
    if (ind) for (int mn = 0; mn < 4; mn++) push(1, mn, op, 1'b1);
    for (int mn = 0; mn < 4; mn++) push(2, mn, op, 1'b1);
    repeat (ind ? 12 : 8) @(posedge clk);
    #1;
  endtask

  task automatic run_halt(int idle);
    ir_op  = 5'd0;
    ir_ind = 1'b0;
    for (int mn = 0; mn < 4; mn++) push(0, mn, 0, 1'b1);
    for (int k = 0; k < idle; k++) push(2, 0, 0, 1'b0);
    repeat (4 + idle) @(posedge clk);
    #1;
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [38:0] got;
        it  = q.pop_front();
        got = {major, minor, run, b1_src, b2_src, b3_load, alu_op, shift_ctl,
               mem_rd, mem_wr, stall, run_clr};
        checks++;
        if (got !== it.v) begin
          fails++;
          $display("FAIL %s: got %b expected %b", it.req, got, it.v);
        end
        checks++;
        if ($countones(b1_src) > 1 || $countones(b2_src) > 1 || $countones(alu_op) > 1) begin
          fails++;
          $display("FAIL R12: b1=%b b2=%b alu=%b expected at most one bit each",
                   b1_src, b2_src, alu_op);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: first cycle after reset is Fetch T0 with run set
    run_instr(1, 1'b0, "R1");
    run_instr(2, 1'b0);
    run_instr(3, 1'b0);
    run_instr(8, 1'b0);
    run_instr(9, 1'b0);
    run_instr(10, 1'b0);
    run_instr(11, 1'b0);      // R11: no execute actions
    run_instr(12, 1'b1);      // R2/R4: indirect through Defer
    run_instr(13, 1'b0);
    run_instr(14, 1'b1);
    run_instr(15, 1'b0);
    for (int op = 16; op <= 25; op++) run_instr(op, 1'b0);
    run_instr(5, 1'b0);       // R11: unassigned, bit 4 clear
    run_instr(27, 1'b0);      // R5/R11: unassigned, bit 4 set
    run_instr(12, 1'b0);
    run_halt(4);              // R8: halt then frozen cycles
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    run_instr(21, 1'b1, "R1");
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule